// File: doc/BRIEF.md
# Bit-Serial Early-Exit SAD Matcher

This block scores candidate reference blocks against a current block of pixels by their sum of absolute differences (SAD) and keeps the best one. Every pixel pair has its own small processing element. An element takes in one bit of each operand per cycle, starting at the most significant bit. The elements' one-bit results are summed across the array and folded into a shared accumulator. After eight cycles, one per bit plane, the accumulator holds the exact SAD.

After each plane, a lower bound on the final SAD is derived from the partial result. The candidate is abandoned as soon as that bound shows it cannot beat the best SAD held so far. This frees the array early for the next candidate. Larger block sizes are covered by setting the pixel-count parameter: the reduction tree simply combines more elements.

A search opens with a start strobe. Candidates, each tagged with an index, are offered through a valid/ready pair. The last one is marked. A one-cycle done pulse announces that the best SAD and its index are final.

Top module: `sad_serial_array`

## Requirements
- R1: After reset `best_sad_o` is all ones (4095 for 16 pixels), `best_idx_o` is 0 and `done_o` and `cand_ready_o` are low. The cycle after `start_i` shows the same best values, `done_o` low and `cand_ready_o` high.
- R2: A candidate is taken at a clock edge where `cand_valid_i` and `cand_ready_o` are both high. `cand_ready_o` is then low until that candidate's evaluation ends. After the candidate flagged by `cand_last_i` ends, `cand_ready_o` stays low until the next `start_i`. Offers made while it is low change neither `best_sad_o` nor `best_idx_o`.
- R3: Bit planes are processed one per cycle, from bit 7 down to bit 0. A candidate that is not cut short keeps `cand_ready_o` low for exactly 8 cycles.
- R4: A candidate's SAD is the exact sum over all pixels of |cur - ref|, with 8-bit unsigned pixels packed at bits [8p+7:8p] for pixel p. A SAD strictly below the stored best replaces both `best_sad_o` and `best_idx_o`.
- R5: A candidate whose SAD equals the stored best leaves `best_idx_o` unchanged, so the earlier candidate wins ties.
- R6: The test runs after each plane k from 7 down to 1. Let H be the sum over pixels of |(cur>>k) - (ref>>k)|, and let n be the number of pixels where (cur>>k) differs from (ref>>k). If (H - n)·2^k is greater than or equal to the stored best, the candidate is dropped after 8 - k busy cycles and the results are left as they were.
- R7: `done_o` goes high for exactly one cycle: the cycle after the last candidate ends, in which the final results are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new search and sets the best SAD to all ones |
| cand_valid_i | input | 1 | A candidate is offered |
| cand_last_i | input | 1 | The offered candidate is the final one of the search |
| cand_idx_i | input | IDX_W (6) | Index of the offered candidate |
| cur_blk_i | input | NPIX*PIX_W (128) | Current block, pixel p at bits [8p+7:8p] |
| ref_blk_i | input | NPIX*PIX_W (128) | Candidate reference block, same packing |
| cand_ready_o | output | 1 | The array can take a candidate |
| best_sad_o | output | SAD_W (12) | Lowest SAD found so far |
| best_idx_o | output | IDX_W (6) | Index of the lowest-SAD candidate |
| done_o | output | 1 | One-cycle pulse when the search ends |

## Verification
A processing element that tracks the wrong sign direction makes the SAD wrong at the port as soon as that candidate ends. The error is then carried into every later comparison of the search. A bound that is too loose or too tight does not change the final result at once. It does show up in the very next candidate, as a `cand_ready_o` low window whose length does not match the one predicted from the pixel data. An update on a tie shows up as a changed `best_idx_o` with no drop in `best_sad_o`.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_EVAL = 2'd2
  } srch_state_e;
endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [PIX_W-1:0]  cur_i,
  input  logic [PIX_W-1:0]  ref_i,
  output logic signed [1:0] contrib_o,
  output logic              started_o
);
  logic [PIX_W-1:0] cur_sr_q, ref_sr_q;
  logic started_q, dir_q, started_nx, dir_nx;
  logic a_b, r_b, big_b, small_b;

  assign a_b = cur_sr_q[PIX_W-1];
  assign r_b = ref_sr_q[PIX_W-1];
  assign big_b   = dir_q ? a_b : r_b;
  assign small_b = dir_q ? r_b : a_b;

  // first differing bit fixes which operand is larger; after that the
  // high-part difference grows as 2h + (big - small)
  always_comb begin
    started_nx = started_q;
    dir_nx     = dir_q;
    contrib_o  = 2'sd0;
    if (!started_q) begin
      if (a_b != r_b) begin
        started_nx = 1'b1;
        dir_nx     = a_b;
        contrib_o  = 2'sd1;
      end
    end else if (big_b && !small_b) begin
      contrib_o = 2'sd1;
    end else if (!big_b && small_b) begin
      contrib_o = -2'sd1;
    end
  end

  assign started_o = started_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_sr_q  <= '0;
      ref_sr_q  <= '0;
      started_q <= 1'b0;
      dir_q     <= 1'b0;
    end else if (load_i) begin
      cur_sr_q  <= cur_i;
      ref_sr_q  <= ref_i;
      started_q <= 1'b0;
      dir_q     <= 1'b0;
    end else if (en_i) begin
      cur_sr_q  <= {cur_sr_q[PIX_W-2:0], 1'b0};
      ref_sr_q  <= {ref_sr_q[PIX_W-2:0], 1'b0};
      started_q <= started_nx;
      dir_q     <= dir_nx;
    end
  end

  // R4
  started_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && en_i && !load_i) |=> started_q);
endmodule

// File: rtl/sad_reduce.sv
module sad_reduce #(
  parameter int NPIX = 16,
  localparam int SUM_W = $clog2(NPIX + 1) + 1,
  localparam int CNT_W = $clog2(NPIX + 1)
) (
  input  logic [2*NPIX-1:0]        contrib_i,
  input  logic [NPIX-1:0]          started_i,
  output logic signed [SUM_W-1:0]  sum_o,
  output logic [CNT_W-1:0]         cnt_o
);
  always_comb begin
    sum_o = '0;
    cnt_o = '0;
    for (int p = 0; p < NPIX; p++) begin
      sum_o = sum_o + {{(SUM_W-2){contrib_i[2*p+1]}}, contrib_i[2*p +: 2]};
      cnt_o = cnt_o + CNT_W'(started_i[p]);
    end
  end
endmodule

// File: rtl/sad_bound.sv
module sad_bound #(
  parameter int SAD_W = 12,
  parameter int PIX_W = 8,
  parameter int CNT_W = 5,
  localparam int PL_W = $clog2(PIX_W),
  localparam int LB_W = SAD_W + 1 + PIX_W
) (
  input  logic [SAD_W:0]   acc_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PL_W-1:0]  plane_i,
  input  logic [SAD_W-1:0] min_i,
  output logic             kill_o
);
  logic [LB_W-1:0] base, lb;

  // each started pixel has high-part difference h >= 1 and its true
  // difference exceeds (h-1)*2^k, so (sum h - started)*2^k is a floor
  assign base   = LB_W'(acc_i) - LB_W'(cnt_i);
  assign lb     = base << plane_i;
  assign kill_o = (plane_i != '0) && (lb >= LB_W'(min_i));
endmodule

// File: rtl/sad_serial_array.sv
module sad_serial_array #(
  parameter int NPIX  = 16,
  parameter int PIX_W = 8,
  parameter int IDX_W = 6,
  localparam int SAD_W = PIX_W + $clog2(NPIX),
  localparam int BLK_W = NPIX * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cand_valid_i,
  input  logic             cand_last_i,
  input  logic [IDX_W-1:0] cand_idx_i,
  input  logic [BLK_W-1:0] cur_blk_i,
  input  logic [BLK_W-1:0] ref_blk_i,
  output logic             cand_ready_o,
  output logic [SAD_W-1:0] best_sad_o,
  output logic [IDX_W-1:0] best_idx_o,
  output logic             done_o
);
  import sad_pkg::*;

  localparam int PL_W  = $clog2(PIX_W);
  localparam int SUM_W = $clog2(NPIX + 1) + 1;
  localparam int CNT_W = $clog2(NPIX + 1);
  localparam int ACC_W = SAD_W + 2;

  srch_state_e state_q;
  logic [PL_W-1:0]  plane_q;
  logic signed [ACC_W-1:0] acc_q, acc_nx, sum_ext;
  logic [IDX_W-1:0] idx_q;
  logic last_q, done_q;
  logic [SAD_W-1:0] best_sad_q;
  logic [IDX_W-1:0] best_idx_q;

  logic accept, run, last_plane, kill, finish, better;
  logic [2*NPIX-1:0] contrib;
  logic [NPIX-1:0]   started;
  logic signed [SUM_W-1:0] plane_sum;
  logic [CNT_W-1:0] started_cnt;
  logic [SAD_W-1:0] sad_fin;

  assign cand_ready_o = (state_q == ST_OPEN);
  assign accept = cand_ready_o && cand_valid_i && !start_i;
  assign run    = (state_q == ST_EVAL);

  for (genvar p = 0; p < NPIX; p++) begin : g_pe
    logic signed [1:0] c;
    sad_pe #(.PIX_W(PIX_W)) u_pe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (accept),
      .en_i     (run),
      .cur_i    (cur_blk_i[p*PIX_W +: PIX_W]),
      .ref_i    (ref_blk_i[p*PIX_W +: PIX_W]),
      .contrib_o(c),
      .started_o(started[p])
    );
    assign contrib[2*p +: 2] = c;
  end

  sad_reduce #(.NPIX(NPIX)) u_reduce (
    .contrib_i(contrib),
    .started_i(started),
    .sum_o    (plane_sum),
    .cnt_o    (started_cnt)
  );

  assign sum_ext = {{(ACC_W-SUM_W){plane_sum[SUM_W-1]}}, plane_sum};
  assign acc_nx  = (acc_q <<< 1) + sum_ext;
  assign sad_fin = acc_nx[SAD_W-1:0];

  sad_bound #(.SAD_W(SAD_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_bound (
    .acc_i  (acc_nx[SAD_W:0]),
    .cnt_i  (started_cnt),
    .plane_i(plane_q),
    .min_i  (best_sad_q),
    .kill_o (kill)
  );

  assign last_plane = (plane_q == '0);
  assign finish     = run && (kill || last_plane);
  assign better     = run && last_plane && (sad_fin < best_sad_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      plane_q    <= '0;
      acc_q      <= '0;
      idx_q      <= '0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      best_sad_q <= '1;
      best_idx_q <= '0;
    end else if (start_i) begin
      state_q    <= ST_OPEN;
      done_q     <= 1'b0;
      best_sad_q <= '1;
      best_idx_q <= '0;
    end else begin
      done_q <= finish && last_q;
      unique case (state_q)
        ST_OPEN: if (accept) begin
          state_q <= ST_EVAL;
          plane_q <= PL_W'(PIX_W - 1);
          acc_q   <= '0;
          idx_q   <= cand_idx_i;
          last_q  <= cand_last_i;
        end
        ST_EVAL: begin
          acc_q   <= acc_nx;
          plane_q <= plane_q - PL_W'(1);
          if (finish) state_q <= last_q ? ST_IDLE : ST_OPEN;
          if (better) begin
            best_sad_q <= sad_fin;
            best_idx_q <= idx_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign best_sad_o = best_sad_q;
  assign best_idx_o = best_idx_q;
  assign done_o     = done_q;

  // R1
  start_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (&best_sad_o && best_idx_o == '0 && !done_o && cand_ready_o));
  // R2
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && cand_ready_o && !start_i) |=> !cand_ready_o);
  // R4
  acc_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> !acc_nx[ACC_W-1]);
  // R4
  best_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (best_sad_o <= $past(best_sad_o)));
  // R5
  idx_needs_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(best_idx_o) || best_sad_o < $past(best_sad_o)));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_sad_serial_array.sv
module sim_sad_serial_array;
  localparam int NPIX = 16;
  localparam int PW   = 8;
  localparam int IW   = 6;
  localparam int SW   = PW + $clog2(NPIX);
  localparam int BW   = NPIX * PW;
  localparam int ONES = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [BW-1:0] cur = '0, rf = '0;
  logic ready, done;
  logic [SW-1:0] best_sad;
  logic [IW-1:0] best_idx;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int mdl_min, mdl_idx;

  always #5 clk = ~clk;

  sad_serial_array u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cand_valid_i(valid),
    .cand_last_i(last), .cand_idx_i(idx), .cur_blk_i(cur), .ref_blk_i(rf),
    .cand_ready_o(ready), .best_sad_o(best_sad), .best_idx_o(best_idx),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pix(input logic [BW-1:0] b, input int p);
    return int'(b[p*PW +: PW]);
  endfunction

  function automatic int exp_sad(input logic [BW-1:0] c, input logic [BW-1:0] r);
    int s = 0;
    for (int p = 0; p < NPIX; p++) begin
      int d = pix(c, p) - pix(r, p);
      s += (d < 0) ? -d : d;
    end
    return s;
  endfunction

  // R6 busy cycles predicted from the lower bound rule
  function automatic int exp_busy(input logic [BW-1:0] c, input logic [BW-1:0] r, input int mn);
    for (int k = PW - 1; k >= 1; k--) begin
      int h = 0, n = 0;
      for (int p = 0; p < NPIX; p++) begin
        int d = (pix(c, p) >> k) - (pix(r, p) >> k);
        if (d != 0) n++;
        h += (d < 0) ? -d : d;
      end
      if (((h - n) << k) >= mn) return PW - k;
    end
    return PW;
  endfunction

  function automatic logic [BW-1:0] rnd_blk();
    logic [BW-1:0] b;
    for (int p = 0; p < NPIX; p++) b[p*PW +: PW] = PW'($urandom_range(0, 255));
    return b;
  endfunction

  function automatic logic [BW-1:0] near_blk(input logic [BW-1:0] c, input int span);
    logic [BW-1:0] b;
    for (int p = 0; p < NPIX; p++) begin
      int v = pix(c, p) + $urandom_range(0, 2*span) - span;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      b[p*PW +: PW] = PW'(v);
    end
    return b;
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    mdl_min = ONES; mdl_idx = 0;
    chk(best_sad == SW'(ONES), "R1 start best_sad", int'(best_sad), ONES);
    chk(best_idx == '0 && !done, "R1 start idx/done", int'(best_idx), 0);
    chk(ready, "R1 ready after start", int'(ready), 1);
  endtask

  task automatic run_cand(input logic [BW-1:0] c, input logic [BW-1:0] r,
                          input int id, input bit lst);
    int busy = 0, eb, es;
    eb = exp_busy(c, r, mdl_min);
    es = exp_sad(c, r);
    @(negedge clk);
    cur = c; rf = r; idx = IW'(id); last = lst; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    while (!ready && !done && busy < 20) begin
      busy++;
      @(negedge clk);
    end
    if (eb == PW) chk(busy == eb, "R3 full evaluation cycles", busy, eb);
    else chk(busy == eb, "R6 early termination cycles", busy, eb);
    if (es < mdl_min) begin mdl_min = es; mdl_idx = id; end
    chk(int'(best_sad) == mdl_min, "R4 best_sad", int'(best_sad), mdl_min);
    chk(int'(best_idx) == mdl_idx, "R4 best_idx", int'(best_idx), mdl_idx);
    chk(done == lst, "R7 done at end of last", int'(done), int'(lst));
    if (lst) begin
      chk(!ready, "R2 ready low after last", int'(ready), 0);
      @(negedge clk);
      chk(!done, "R7 done one cycle", int'(done), 0);
    end
  endtask

  initial begin
    logic [BW-1:0] c, r;
    void'($urandom(32'h5AD0_1234));
    repeat (3) @(negedge clk);
    chk(best_sad == SW'(ONES), "R1 reset best_sad", int'(best_sad), ONES);
    chk(best_idx == '0 && !done && !ready, "R1 reset idx/done/ready", int'(best_idx), 0);
    rst_n = 1'b1;

    // R2 offers before any start are ignored
    c = rnd_blk();
    cur = c; rf = c; valid = 1'b1; idx = 6'd9;
    repeat (4) @(negedge clk);
    chk(!ready, "R2 ready low before start", int'(ready), 0);
    chk(best_sad == SW'(ONES) && best_idx == '0, "R2 offer ignored", int'(best_sad), ONES);
    valid = 1'b0;

    // R3 max difference, full 8 cycles
    do_start();
    c = '1; r = '0;
    run_cand(c, r, 5, 1'b0);
    chk(best_sad == SW'(4080), "R4 maximum SAD", int'(best_sad), 4080);
    run_cand(c, '0, 7, 1'b1);
    chk(best_idx == 6'd5, "R5 tie keeps earlier", int'(best_idx), 5);

    // R2 offers after last are ignored
    valid = 1'b1; cur = c; rf = c; idx = 6'd33;
    repeat (4) @(negedge clk);
    chk(best_sad == SW'(4080) && best_idx == 6'd5, "R2 offer after last ignored", int'(best_sad), 4080);
    valid = 1'b0;

    // R6 perfect match first, then all later candidates cut after one plane
    do_start();
    c = rnd_blk();
    run_cand(c, c, 2, 1'b0);
    for (int i = 0; i < 5; i++) run_cand(c, near_blk(c, 40), 3 + i, i == 4);
    chk(best_sad == '0 && best_idx == 6'd2, "R6 zero best stays", int'(best_sad), 0);

    // R5 equal SAD, different data
    do_start();
    c = rnd_blk();
    r = near_blk(c, 10);
    run_cand(c, r, 11, 1'b0);
    run_cand(r, c, 12, 1'b1);
    chk(best_idx == 6'd11, "R5 mirrored tie", int'(best_idx), 11);

    // random searches with mixed closeness
    for (int s = 0; s < 40; s++) begin
      int ncand = $urandom_range(2, 12);
      do_start();
      c = rnd_blk();
      for (int i = 0; i < ncand; i++) begin
        int mode = $urandom_range(0, 3);
        if (mode == 0) r = rnd_blk();
        else r = near_blk(c, (mode == 1) ? 4 : (mode == 2) ? 20 : 80);
        run_cand(c, r, $urandom_range(0, 63), i == ncand - 1);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule